// File: doc/BRIEF.md
# Host Bus Register Access Controller

This block sits between an asynchronous host bus and the register slots of a dual-channel serial peripheral. It watches an active-low chip select, a read/write direction line, four register-select lines and an active-low interrupt-acknowledge line. From these it produces one-cycle read and write enables for sixteen register slots, captures the write data, registers the selected read data, and drives an active-low transfer acknowledge back to the host.

All sequencing runs on the device reference clock, not on any host clock. Chip select and interrupt acknowledge pass through a two-stage synchroniser before a cycle is recognised. Because of this, a device whose reference clock is stopped never acknowledges anything. The host reset is asserted asynchronously and released synchronously, and the result is handed on to the rest of the device as its reset.

Top module: `hbus_access_ctrl`

## Requirements
- R1: While `host_rst_n` is low, `dev_rst_n` is low and `dtack_n` is high at once, even mid-cycle, and all enables are zero. After `host_rst_n` rises, `dev_rst_n` rises on the second rising `ref_clk` edge.
- R2: A write cycle (`cs_n` low, `rw`=0) with `rsel`=k drives `slot_wr_en` bit k alone high for exactly one `ref_clk` cycle per chip-select assertion. No read enable is driven.
- R3: A read cycle (`cs_n` low, `rw`=1) with `rsel`=k drives `slot_rd_en` bit k alone high for exactly one `ref_clk` cycle per chip-select assertion.
- R4: Count the rising edges from the first edge at which `cs_n` is seen low as edge 0. The enable pulse starts at edge 2 and ends at edge 3.
- R5: `dtack_n` falls at the edge that ends the enable pulse, one reference clock after it began. It stays low while the cycle's select input stays low.
- R6: `dtack_n` returns high without waiting for a clock edge when the cycle's select input (`cs_n`, or `iack_n` for an acknowledge cycle) goes high. A new cycle starts only after the release has passed the synchroniser.
- R7: On a read, `host_rdata` holds bits [k*8 +: 8] of `slot_rdata`, loaded at the edge where `dtack_n` falls, and it stays stable while acknowledged.
- R8: During a write pulse, `slot_wdata` equals the `host_wdata` value present at the edge that starts the pulse.
- R9: An interrupt-acknowledge cycle (`iack_n` low) produces no enables and is acknowledged with the same timing as R4/R5, with `host_rdata` equal to `ivec`. If chip select and interrupt acknowledge are recognised at the same edge, the interrupt acknowledge wins.
- R10: While `ref_clk` is stopped, an asserted `cs_n` or `iack_n` produces no acknowledge and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Device reference clock |
| host_rst_n | input | 1 | Host reset, active low, asynchronous |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | Direction: 1 read, 0 write |
| rsel | input | 4 | Register slot index |
| iack_n | input | 1 | Interrupt acknowledge, active low |
| host_wdata | input | 8 | Data driven by the host on writes |
| slot_rdata | input | 128 | Read values of all sixteen slots, slot k in bits [k*8 +: 8] |
| ivec | input | 8 | Interrupt vector returned on acknowledge cycles |
| dev_rst_n | output | 1 | Device reset, released in step with `ref_clk` |
| slot_wr_en | output | 16 | One-hot write enable pulse |
| slot_rd_en | output | 16 | One-hot read enable pulse |
| slot_wdata | output | 8 | Captured write data |
| host_rdata | output | 8 | Registered read data toward the host |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
The hardest case to reach from the ports is the absent reference clock. In that case nothing may change at all, not even the synchroniser stages. The bench gates its own clock off while the clock is low, holds chip select and then interrupt acknowledge low for many clock periods, and checks that the acknowledge and the enables never move. It then restarts the clock with the bus idle and checks that no phantom cycle follows. A reset asserted in the middle of an acknowledged cycle is the other awkward point, and the bench checks the acknowledge at once rather than at the next edge.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_HOLD   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hbus_rst_sync.sv
module hbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_act,
  input  logic iack_act,
  output logic start,
  output logic start_iack,
  output logic strobe,
  output logic ack,
  output logic cyc_iack
);
  seq_state_e state, state_nx;
  logic       live;

  assign start      = (state == ST_IDLE) && (cs_act || iack_act);
  assign start_iack = iack_act;
  assign live       = cyc_iack ? iack_act : cs_act;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (start) state_nx = ST_STROBE;
      ST_STROBE: state_nx = ST_HOLD;
      ST_HOLD:   if (!live) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cyc_iack <= 1'b0;
    end else begin
      state <= state_nx;
      if (start) cyc_iack <= iack_act;
    end
  end

  assign strobe = (state == ST_STROBE);
  assign ack    = (state == ST_HOLD);

  // R5
  ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(strobe));

  // R6
  hold_while_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && live) |=> ack);
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode #(
  parameter int SEL_W = 4,
  parameter int DW    = 8,
  localparam int SLOTS = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_iack,
  input  logic               strobe,
  input  logic               rw,
  input  logic [SEL_W-1:0]   rsel,
  input  logic [DW-1:0]      wdata,
  input  logic [SLOTS*DW-1:0] slot_rdata,
  input  logic [DW-1:0]      ivec,
  output logic [SLOTS-1:0]   wr_en,
  output logic [SLOTS-1:0]   rd_en,
  output logic [DW-1:0]      wdata_q,
  output logic [DW-1:0]      rdata
);
  logic [SLOTS-1:0] hit;
  logic [SEL_W-1:0] addr_q;
  logic             iack_q;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_hit
      assign hit[g] = (rsel == SEL_W'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= '0;
      rd_en   <= '0;
      addr_q  <= '0;
      iack_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      wr_en <= (start && !start_iack && !rw) ? hit : '0;
      rd_en <= (start && !start_iack &&  rw) ? hit : '0;
      if (start) begin
        addr_q  <= rsel;
        iack_q  <= start_iack;
        wdata_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (strobe) rdata <= iack_q ? ivec : slot_rdata[addr_q*DW +: DW];
  end

  // R2
  enables_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_en}));

  // R3
  enable_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|{wr_en, rd_en}) |=> !(|{wr_en, rd_en}));
endmodule

// File: rtl/hbus_access_ctrl.sv
module hbus_access_ctrl #(
  parameter int SEL_W       = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SLOTS = 1 << SEL_W
) (
  input  logic                ref_clk,
  input  logic                host_rst_n,
  input  logic                cs_n,
  input  logic                rw,
  input  logic [SEL_W-1:0]    rsel,
  input  logic                iack_n,
  input  logic [DW-1:0]       host_wdata,
  input  logic [SLOTS*DW-1:0] slot_rdata,
  input  logic [DW-1:0]       ivec,
  output logic                dev_rst_n,
  output logic [SLOTS-1:0]    slot_wr_en,
  output logic [SLOTS-1:0]    slot_rd_en,
  output logic [DW-1:0]       slot_wdata,
  output logic [DW-1:0]       host_rdata,
  output logic                dtack_n
);
  logic [1:0] sel_raw, sel_sync;
  logic start, start_iack, strobe, ack_w, cyc_iack, live_raw;

  hbus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(ref_clk), .arst_n(host_rst_n), .srst_n(dev_rst_n)
  );

  assign sel_raw = {~iack_n, ~cs_n};

  hbus_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(dev_rst_n), .d(sel_raw), .q(sel_sync)
  );

  hbus_seq u_seq (
    .clk(ref_clk), .rst_n(dev_rst_n),
    .cs_act(sel_sync[0]), .iack_act(sel_sync[1]),
    .start(start), .start_iack(start_iack), .strobe(strobe),
    .ack(ack_w), .cyc_iack(cyc_iack)
  );

  hbus_decode #(.SEL_W(SEL_W), .DW(DW)) u_dec (
    .clk(ref_clk), .rst_n(dev_rst_n),
    .start(start), .start_iack(start_iack), .strobe(strobe),
    .rw(rw), .rsel(rsel), .wdata(host_wdata),
    .slot_rdata(slot_rdata), .ivec(ivec),
    .wr_en(slot_wr_en), .rd_en(slot_rd_en),
    .wdata_q(slot_wdata), .rdata(host_rdata)
  );

  assign live_raw = cyc_iack ? ~iack_n : ~cs_n;
  assign dtack_n  = ~(ack_w & live_raw & dev_rst_n);

  // R5
  ack_follows_enable_chk: assert property (@(posedge ref_clk) disable iff (!dev_rst_n)
    (|{slot_wr_en, slot_rd_en}) |=> ack_w);

  // R7
  rdata_stable_chk: assert property (@(posedge ref_clk) disable iff (!dev_rst_n)
    (ack_w && $past(ack_w)) |-> $stable(host_rdata));
endmodule

// File: tb/hbus_access_ctrl_bench.sv
module hbus_access_ctrl_bench;
  localparam int PER   = 10;
  localparam int SEL_W = 4;
  localparam int DW    = 8;
  localparam int SLOTS = 1 << SEL_W;

  logic ref_clk = 1'b0, clk_run = 1'b1;
  logic host_rst_n, cs_n, rw, iack_n;
  logic [SEL_W-1:0] rsel;
  logic [DW-1:0] host_wdata, ivec, slot_wdata, host_rdata;
  logic [SLOTS*DW-1:0] slot_rdata;
  logic dev_rst_n, dtack_n;
  logic [SLOTS-1:0] slot_wr_en, slot_rd_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(PER/2) if (clk_run) ref_clk = ~ref_clk;

  hbus_access_ctrl u_hbus_access_ctrl (
    .ref_clk(ref_clk), .host_rst_n(host_rst_n), .cs_n(cs_n), .rw(rw),
    .rsel(rsel), .iack_n(iack_n), .host_wdata(host_wdata),
    .slot_rdata(slot_rdata), .ivec(ivec), .dev_rst_n(dev_rst_n),
    .slot_wr_en(slot_wr_en), .slot_rd_en(slot_rd_en),
    .slot_wdata(slot_wdata), .host_rdata(host_rdata), .dtack_n(dtack_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] slot_val(input int k, input int salt);
    return DW'((k * 29 + salt * 7 + 3) & 8'hff);
  endfunction

  task automatic load_slots(input int salt);
    for (int k = 0; k < SLOTS; k++) slot_rdata[k*DW +: DW] = slot_val(k, salt);
  endtask

  // One bus cycle; kind 0 write, 1 read, 2 interrupt acknowledge, 3 both selects
  task automatic bus_cycle(input int kind, input int k, input logic [DW-1:0] wd);
    logic [SLOTS-1:0] exp_w, exp_r;
    logic [DW-1:0] exp_d;
    exp_w = (kind == 0) ? SLOTS'(1) << k : '0;
    exp_r = (kind == 1) ? SLOTS'(1) << k : '0;
    exp_d = (kind >= 2) ? ivec : slot_val(k, k + 1);
    load_slots(k + 1);
    @(negedge ref_clk);
    rsel = SEL_W'(k); rw = (kind == 1); host_wdata = wd;
    if (kind != 2) cs_n = 1'b0;
    if (kind >= 2) iack_n = 1'b0;
    for (int e = 0; e < 2; e++) begin
      @(negedge ref_clk);
      chk(slot_wr_en == 0 && slot_rd_en == 0 && dtack_n, "R4 no early pulse", {slot_wr_en, slot_rd_en}, 0);
    end
    @(negedge ref_clk);
    chk(slot_wr_en == exp_w, (kind >= 2) ? "R9 no wr enable" : "R2 wr enable", slot_wr_en, exp_w);
    chk(slot_rd_en == exp_r, (kind >= 2) ? "R9 no rd enable" : "R3 rd enable", slot_rd_en, exp_r);
    chk(dtack_n == 1'b1, "R5 ack not with pulse", dtack_n, 1);
    if (kind == 0) chk(slot_wdata == wd, "R8 write data", slot_wdata, wd);
    @(negedge ref_clk);
    chk(dtack_n == 1'b0, "R5 ack after pulse", dtack_n, 0);
    chk(slot_wr_en == 0 && slot_rd_en == 0, "R4 pulse ends", {slot_wr_en, slot_rd_en}, 0);
    if (kind != 0) chk(host_rdata == exp_d, (kind >= 2) ? "R9 vector" : "R7 read data", host_rdata, exp_d);
    load_slots(k + 9);
    repeat (2) begin
      @(negedge ref_clk);
      chk(dtack_n == 1'b0, "R5 ack held", dtack_n, 0);
      chk(slot_wr_en == 0 && slot_rd_en == 0, "R2 once per select", {slot_wr_en, slot_rd_en}, 0);
      if (kind != 0) chk(host_rdata == exp_d, "R7 rdata stable", host_rdata, exp_d);
    end
    cs_n = 1'b1; iack_n = 1'b1;
    #1;
    chk(dtack_n == 1'b1, "R6 immediate release", dtack_n, 1);
    repeat (4) begin
      @(negedge ref_clk);
      chk(dtack_n && slot_wr_en == 0 && slot_rd_en == 0, "R6 no retrigger", {dtack_n, slot_wr_en, slot_rd_en}, 1 << 32);
    end
  endtask

  initial begin
    #(PER * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    host_rst_n = 1'b0; cs_n = 1'b1; iack_n = 1'b1; rw = 1'b0; rsel = '0;
    host_wdata = '0; ivec = 8'hA5; slot_rdata = '0;
    #2;
    chk(dev_rst_n == 1'b0, "R1 reset asserted", dev_rst_n, 0);
    chk(dtack_n == 1'b1, "R1 ack idle in reset", dtack_n, 1);
    repeat (3) @(negedge ref_clk);
    chk(slot_wr_en == 0 && slot_rd_en == 0, "R1 enables clear", {slot_wr_en, slot_rd_en}, 0);
    host_rst_n = 1'b1;
    @(negedge ref_clk);
    chk(dev_rst_n == 1'b0, "R1 still in reset after one edge", dev_rst_n, 0);
    @(negedge ref_clk);
    chk(dev_rst_n == 1'b1, "R1 released after two edges", dev_rst_n, 1);

    for (int k = 0; k < SLOTS; k++) begin
      bus_cycle(0, k, DW'(8'h3C ^ (k * 11)));
      bus_cycle(1, k, 8'h00);
    end
    ivec = 8'h5A; bus_cycle(2, 3, 8'h00);
    ivec = 8'hC3; bus_cycle(3, 6, 8'h00);

    // R10: stopped reference clock
    @(negedge ref_clk);
    clk_run = 1'b0;
    #(PER);
    rw = 1'b1; rsel = 4'd2; cs_n = 1'b0;
    #(PER * 20);
    chk(dtack_n == 1'b1, "R10 no ack without clock", dtack_n, 1);
    chk(slot_wr_en == 0 && slot_rd_en == 0, "R10 no enable without clock", {slot_wr_en, slot_rd_en}, 0);
    cs_n = 1'b1; iack_n = 1'b0;
    #(PER * 20);
    chk(dtack_n == 1'b1, "R10 no iack ack without clock", dtack_n, 1);
    iack_n = 1'b1;
    #(PER);
    clk_run = 1'b1;
    repeat (6) begin
      @(negedge ref_clk);
      chk(dtack_n && slot_wr_en == 0 && slot_rd_en == 0, "R10 no phantom cycle", {dtack_n, slot_wr_en, slot_rd_en}, 1 << 32);
    end

    // R1: reset in the middle of an acknowledged cycle
    @(negedge ref_clk);
    rw = 1'b0; rsel = 4'd9; cs_n = 1'b0;
    repeat (5) @(negedge ref_clk);
    chk(dtack_n == 1'b0, "R5 ack before mid reset", dtack_n, 0);
    host_rst_n = 1'b0;
    #1;
    chk(dtack_n == 1'b1, "R1 ack drops at reset", dtack_n, 1);
    chk(dev_rst_n == 1'b0, "R1 device reset immediate", dev_rst_n, 0);
    cs_n = 1'b1;
    @(negedge ref_clk);
    host_rst_n = 1'b1;
    repeat (3) @(negedge ref_clk);
    chk(dev_rst_n == 1'b1, "R1 recovered", dev_rst_n, 1);
    bus_cycle(1, 15, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule